// File: doc/BRIEF.md
# Sixteen-Bit Instruction Execute Stage

This block is the execute stage of a small register-register machine whose instructions are all 16 bits wide. Each instruction word holds a 4-bit opcode in bits [15:12] and three 4-bit fields below it. The surrounding pipeline reads the general registers named by the three fields and presents their values on `opnd_x` ([11:8]), `opnd_y` ([7:4]) and `opnd_z` ([3:0]) alongside the word.

One clock edge after an instruction is accepted, the stage presents its outcome as exactly one kind of action, or none:
- a register write-back of the computed value;
- a taken branch with its target address;
- a memory load or store request;
- an access request to the special registers.

The register files, fetch sequencing, data memory and special registers are all outside the block. So is the write of loaded or special-register data into the general registers.

Arithmetic, bitwise OR, shifts, signed compare and byte-half immediate loads all go through one result path. A parameter can remove the multiplier or the divider; their opcodes then return zero.

Top module: `ex16_execute`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `out_valid`, `wb_en`, `br_taken`, `mem_rd`, `mem_wr`, `spr_req` and `spr_write` are all 0.
- R2: Every output is registered. It reflects the instruction presented with `in_valid` high on the previous rising edge. An instruction presented with `in_valid` low leaves all enables and `out_valid` at 0.
- R3: Opcode 10 writes `opnd_y + opnd_z`, opcode 14 writes `opnd_y | opnd_z`, and opcode 2 writes `0 - opnd_y`, all modulo 2^16. Every register write-back sets `wb_en` and gives `wb_idx` = instruction bits [11:8].
- R4: Opcode 6 writes the low 16 bits of `opnd_y * opnd_z`. Opcode 7 writes the unsigned quotient `opnd_y / opnd_z`, or 0xFFFF when `opnd_z` is 0.
- R5: Opcode 8 writes 1 when `opnd_y` is less than `opnd_z` as signed 16-bit numbers, and 0 otherwise.
- R6: Opcode 5 treats bits [3:0] as a signed amount s from -8 to 7. It writes `opnd_y` shifted left by s when s >= 0, and shifted right logically by -s when s < 0.
- R7: Opcode 3 writes {bits [7:0], `opnd_x`[7:0]}. Opcode 4 writes {`opnd_x`[15:8], bits [7:0]}.
- R8: Opcode 0 sets `br_taken` when `opnd_x` equals `opnd_y`, and opcode 1 sets it when they differ. When `br_taken` is set, `br_target` equals `opnd_z`.
- R9: Opcode 12 sets `mem_rd` and opcode 13 sets `mem_wr`. For both, `mem_addr` = `opnd_y` + bits [3:0] sign-extended. For a store, `mem_wdata` = `opnd_x`.
- R10: Opcode 15 sets `spr_req`, with `spr_write` = bit [7], `spr_idx` = bits [6:0] and `spr_wdata` = `opnd_x`.
- R11: Opcodes 9 and 11 leave `wb_en`, `br_taken`, `mem_rd`, `mem_wr` and `spr_req` at 0, while `out_valid` still follows R2.
- R12: At most one of `wb_en`, `br_taken`, `mem_rd`, `mem_wr` and `spr_req` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and operands are valid |
| instr | input | 16 | Instruction word |
| opnd_x | input | 16 | Value of register named by bits [11:8] |
| opnd_y | input | 16 | Value of register named by bits [7:4] |
| opnd_z | input | 16 | Value of register named by bits [3:0] |
| out_valid | output | 1 | An executed instruction is presented |
| wb_en | output | 1 | Write `wb_data` to register `wb_idx` |
| wb_idx | output | 4 | Destination general register |
| wb_data | output | 16 | Result value |
| br_taken | output | 1 | Branch is taken |
| br_target | output | 16 | Branch destination address |
| mem_rd | output | 1 | Load request |
| mem_wr | output | 1 | Store request |
| mem_addr | output | 16 | Load or store address |
| mem_wdata | output | 16 | Store data |
| spr_req | output | 1 | Special register access |
| spr_write | output | 1 | Access writes (1) or reads (0) |
| spr_idx | output | 7 | Special register number |
| spr_wdata | output | 16 | Value to write to the special register |

## Verification
The branch compare and the sign-extended address adder share operands with the result path. A single cycle therefore produces a branch decision, a memory address and a result value, and only one of them may be enabled. The sweep drives every opcode against the same operand patterns. Equal and unequal `opnd_x`/`opnd_y` pairs, negative offsets and zero divisors all occur. In every cycle the bench checks the complete enable vector against its model, so a leaked enable shows up next to the intended action.

// File: rtl/ex16_pkg.sv
package ex16_pkg;
   localparam int OPC_W = 4;
   localparam int FLD_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_BEQ  = 4'd0,
      OP_BNE  = 4'd1,
      OP_NEG  = 4'd2,
      OP_HIB  = 4'd3,
      OP_LOB  = 4'd4,
      OP_SHF  = 4'd5,
      OP_MUL  = 4'd6,
      OP_DIV  = 4'd7,
      OP_SLT  = 4'd8,
      OP_ADD  = 4'd10,
      OP_LD   = 4'd12,
      OP_ST   = 4'd13,
      OP_OR   = 4'd14,
      OP_SPR  = 4'd15
   } ex16_op_e;

   typedef struct packed {
      logic wb;
      logic br;
      logic rd;
      logic wr;
      logic spr;
   } ex16_act_t;
endpackage

// File: rtl/ex16_alu.sv
module ex16_alu
   import ex16_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int IMM_W   = 8,
   parameter int SHAMT_W = 4,
   parameter bit MUL_EN  = 1'b1,
   parameter bit DIV_EN  = 1'b1
) (
   input  ex16_op_e           opc,
   input  logic [IMM_W-1:0]   imm,
   input  logic [DATA_W-1:0]  x,
   input  logic [DATA_W-1:0]  y,
   input  logic [DATA_W-1:0]  z,
   output logic [DATA_W-1:0]  result
);
   localparam int MAG_W = SHAMT_W + 1;

   logic [SHAMT_W-1:0] shamt;
   logic [SHAMT_W-1:0] neg_amt;
   logic [MAG_W-1:0]   mag;
   logic               shr;
   logic [DATA_W-1:0]  shifted;
   logic [DATA_W-1:0]  prod;
   logic [DATA_W-1:0]  quot;

   assign shamt   = imm[SHAMT_W-1:0];
   assign shr     = shamt[SHAMT_W-1];
   assign neg_amt = ~shamt + SHAMT_W'(1);
   assign mag     = shr ? {1'b0, neg_amt} : {1'b0, shamt};
   assign shifted = shr ? (y >> mag) : (y << mag);

   generate
      if (MUL_EN) begin : g_mul
         assign prod = y * z;
      end else begin : g_nomul
         assign prod = '0;
      end
      if (DIV_EN) begin : g_div
         assign quot = (z == '0) ? '1 : (y / z);
      end else begin : g_nodiv
         assign quot = '0;
      end
   endgenerate

   always_comb begin
      result = '0;
      case (opc)
         OP_ADD:  result = y + z;
         OP_OR:   result = y | z;
         OP_NEG:  result = '0 - y;
         OP_MUL:  result = prod;
         OP_DIV:  result = quot;
         OP_SLT:  result = DATA_W'($signed(y) < $signed(z));
         OP_SHF:  result = shifted;
         OP_HIB:  result = {imm, x[IMM_W-1:0]};
         OP_LOB:  result = {x[DATA_W-1:IMM_W], imm};
         default: result = '0;
      endcase
   end
endmodule

// File: rtl/ex16_ctl.sv
module ex16_ctl
   import ex16_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int OFS_W  = 4
) (
   input  ex16_op_e          opc,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [DATA_W-1:0] x,
   input  logic [DATA_W-1:0] y,
   output ex16_act_t         act,
   output logic [DATA_W-1:0] addr
);
   logic eq;

   assign eq   = (x == y);
   assign addr = y + {{(DATA_W-OFS_W){ofs[OFS_W-1]}}, ofs};

   always_comb begin
      act = '0;
      case (opc)
         OP_BEQ: act.br = eq;
         OP_BNE: act.br = ~eq;
         OP_LD:  act.rd = 1'b1;
         OP_ST:  act.wr = 1'b1;
         OP_SPR: act.spr = 1'b1;
         OP_ADD, OP_OR, OP_NEG, OP_MUL, OP_DIV,
         OP_SLT, OP_SHF, OP_HIB, OP_LOB: act.wb = 1'b1;
         default: act = '0;
      endcase
   end
endmodule

// File: rtl/ex16_execute.sv
module ex16_execute
   import ex16_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int IMM_W   = 8,
   parameter int SPR_W   = 7,
   parameter bit MUL_EN  = 1'b1,
   parameter bit DIV_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [15:0]       instr,
   input  logic [DATA_W-1:0] opnd_x,
   input  logic [DATA_W-1:0] opnd_y,
   input  logic [DATA_W-1:0] opnd_z,
   output logic              out_valid,
   output logic              wb_en,
   output logic [FLD_W-1:0]  wb_idx,
   output logic [DATA_W-1:0] wb_data,
   output logic              br_taken,
   output logic [DATA_W-1:0] br_target,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              spr_req,
   output logic              spr_write,
   output logic [SPR_W-1:0]  spr_idx,
   output logic [DATA_W-1:0] spr_wdata
);
   localparam int INSTR_W = OPC_W + 3 * FLD_W;
   localparam int OFS_W   = FLD_W;

   generate
      if (INSTR_W != 16) begin : g_bad_instr
         $error("instruction layout must total 16 bits");
      end
      if (DATA_W != 2 * IMM_W) begin : g_bad_data
         $error("DATA_W must hold exactly two immediate bytes");
      end
      if (SPR_W + 1 != IMM_W) begin : g_bad_spr
         $error("special index plus direction flag must fill the low byte");
      end
   endgenerate

   ex16_op_e          opc;
   ex16_act_t         act;
   logic [DATA_W-1:0] alu_res;
   logic [DATA_W-1:0] ls_addr;

   assign opc = ex16_op_e'(instr[15 -: OPC_W]);

   ex16_alu #(
      .DATA_W (DATA_W),
      .IMM_W  (IMM_W),
      .SHAMT_W(FLD_W),
      .MUL_EN (MUL_EN),
      .DIV_EN (DIV_EN)
   ) i_alu (
      .opc   (opc),
      .imm   (instr[IMM_W-1:0]),
      .x     (opnd_x),
      .y     (opnd_y),
      .z     (opnd_z),
      .result(alu_res)
   );

   ex16_ctl #(
      .DATA_W(DATA_W),
      .OFS_W (OFS_W)
   ) i_ctl (
      .opc (opc),
      .ofs (instr[OFS_W-1:0]),
      .x   (opnd_x),
      .y   (opnd_y),
      .act (act),
      .addr(ls_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         wb_en     <= 1'b0;
         br_taken  <= 1'b0;
         mem_rd    <= 1'b0;
         mem_wr    <= 1'b0;
         spr_req   <= 1'b0;
         spr_write <= 1'b0;
         wb_idx    <= '0;
         wb_data   <= '0;
         br_target <= '0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         spr_idx   <= '0;
         spr_wdata <= '0;
      end else begin
         out_valid <= in_valid;
         wb_en     <= in_valid & act.wb;
         br_taken  <= in_valid & act.br;
         mem_rd    <= in_valid & act.rd;
         mem_wr    <= in_valid & act.wr;
         spr_req   <= in_valid & act.spr;
         spr_write <= in_valid & act.spr & instr[SPR_W];
         wb_idx    <= instr[2*FLD_W +: FLD_W];
         wb_data   <= alu_res;
         br_target <= opnd_z;
         mem_addr  <= ls_addr;
         mem_wdata <= opnd_x;
         spr_idx   <= instr[SPR_W-1:0];
         spr_wdata <= opnd_x;
      end
   end
endmodule

// File: rtl/ex16_execute_chk.sv
module ex16_execute_chk #(
   parameter int DATA_W = 16,
   parameter int SPR_W  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [15:0]       instr,
   input logic [DATA_W-1:0] opnd_x,
   input logic [DATA_W-1:0] opnd_y,
   input logic [DATA_W-1:0] opnd_z,
   input logic              out_valid,
   input logic              wb_en,
   input logic [3:0]        wb_idx,
   input logic [DATA_W-1:0] wb_data,
   input logic              br_taken,
   input logic [DATA_W-1:0] br_target,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [DATA_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              spr_req,
   input logic              spr_write,
   input logic [SPR_W-1:0]  spr_idx,
   input logic [DATA_W-1:0] spr_wdata
);
   logic armed;

   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> !(out_valid | wb_en | br_taken | mem_rd | mem_wr | spr_req | spr_write));

   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      armed && !in_valid |=> !(out_valid | wb_en | br_taken | mem_rd | mem_wr | spr_req));

   a_r3_add_value: assert property (@(posedge clk) disable iff (!rst_n)
      armed && in_valid && instr[15:12] == 4'd10
      |=> wb_en && wb_data == $past(opnd_y + opnd_z) && wb_idx == $past(instr[11:8]));

   a_r7_upper_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
      armed && in_valid && instr[15:12] == 4'd3
      |=> wb_data == {$past(instr[7:0]), $past(opnd_x[7:0])});

   a_r8_beq_taken: assert property (@(posedge clk) disable iff (!rst_n)
      armed && in_valid && instr[15:12] == 4'd0 && opnd_x == opnd_y
      |=> br_taken && br_target == $past(opnd_z));

   a_r9_store_req: assert property (@(posedge clk) disable iff (!rst_n)
      armed && in_valid && instr[15:12] == 4'd13
      |=> mem_wr && mem_wdata == $past(opnd_x)
          && mem_addr == $past(opnd_y + {{(DATA_W-4){instr[3]}}, instr[3:0]}));

   a_r10_spr_req: assert property (@(posedge clk) disable iff (!rst_n)
      armed && in_valid && instr[15:12] == 4'd15
      |=> spr_req && spr_write == $past(instr[7]) && spr_idx == $past(instr[6:0])
          && spr_wdata == $past(opnd_x));

   a_r11_unused_opcode: assert property (@(posedge clk) disable iff (!rst_n)
      armed && (instr[15:12] == 4'd9 || instr[15:12] == 4'd11)
      |=> !(wb_en | br_taken | mem_rd | mem_wr | spr_req));

   a_r12_single_action: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wb_en, br_taken, mem_rd, mem_wr, spr_req}));
endmodule

bind ex16_execute ex16_execute_chk #(.DATA_W(DATA_W), .SPR_W(SPR_W)) i_chk (.*);

// File: tb/test_ex16_execute.sv
module test_ex16_execute;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] instr = '0;
   logic [15:0] opnd_x = '0, opnd_y = '0, opnd_z = '0;
   logic        out_valid, wb_en, br_taken, mem_rd, mem_wr, spr_req, spr_write;
   logic [3:0]  wb_idx;
   logic [15:0] wb_data, br_target, mem_addr, mem_wdata, spr_wdata;
   logic [6:0]  spr_idx;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   ex16_execute i_ex16_execute (.*);

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic string tag(input logic [3:0] op);
      case (op)
         4'd0, 4'd1:        return "R8";
         4'd2, 4'd10, 4'd14: return "R3";
         4'd3, 4'd4:        return "R7";
         4'd5:              return "R6";
         4'd6, 4'd7:        return "R4";
         4'd8:              return "R5";
         4'd12, 4'd13:      return "R9";
         4'd15:             return "R10";
         default:           return "R11";
      endcase
   endfunction

   task automatic run(input logic [15:0] ins, input logic [15:0] x, y, z, input logic v);
      logic [3:0]  op;
      logic        e_wb, e_br, e_rd, e_wr, e_sp, e_sw;
      logic [15:0] e_data, e_addr;
      int          s;
      @(negedge clk);
      in_valid = v; instr = ins; opnd_x = x; opnd_y = y; opnd_z = z;
      op = ins[15:12];
      {e_wb, e_br, e_rd, e_wr, e_sp, e_sw} = '0;
      e_data = '0;
      e_addr = y + {{12{ins[3]}}, ins[3:0]};
      s = ins[3] ? int'(ins[3:0]) - 16 : int'(ins[3:0]);
      case (op)
         4'd0:  e_br = (x == y);
         4'd1:  e_br = (x != y);
         4'd2:  begin e_wb = 1; e_data = 16'(0) - y; end
         4'd3:  begin e_wb = 1; e_data = {ins[7:0], x[7:0]}; end
         4'd4:  begin e_wb = 1; e_data = {x[15:8], ins[7:0]}; end
         4'd5:  begin e_wb = 1; e_data = (s >= 0) ? (y << s) : (y >> (-s)); end
         4'd6:  begin e_wb = 1; e_data = 16'((32'(y) * 32'(z)) & 32'hFFFF); end
         4'd7:  begin e_wb = 1; e_data = (z == 0) ? 16'hFFFF : y / z; end
         4'd8:  begin e_wb = 1; e_data = ($signed(y) < $signed(z)) ? 16'd1 : 16'd0; end
         4'd10: begin e_wb = 1; e_data = y + z; end
         4'd12: e_rd = 1;
         4'd13: e_wr = 1;
         4'd14: begin e_wb = 1; e_data = y | z; end
         4'd15: begin e_sp = 1; e_sw = ins[7]; end
         default: ;
      endcase
      if (!v) {e_wb, e_br, e_rd, e_wr, e_sp, e_sw} = '0;
      @(negedge clk);
      check(v ? tag(op) : "R2", "valid", {31'd0, out_valid}, {31'd0, v});
      check(v ? tag(op) : "R2", "enables", {26'd0, wb_en, br_taken, mem_rd, mem_wr, spr_req, spr_write},
            {26'd0, e_wb, e_br, e_rd, e_wr, e_sp, e_sw});
      check("R12", "one action", {31'd0, 1'b1}, {31'd0, ($countones({wb_en, br_taken, mem_rd, mem_wr, spr_req}) <= 1)});
      if (e_wb) begin
         check(tag(op), "wb_data", {16'd0, wb_data}, {16'd0, e_data});
         check("R3", "wb_idx", {28'd0, wb_idx}, {28'd0, ins[11:8]});
      end
      if (e_br) check("R8", "target", {16'd0, br_target}, {16'd0, z});
      if (e_rd | e_wr) check("R9", "addr", {16'd0, mem_addr}, {16'd0, e_addr});
      if (e_wr) check("R9", "store data", {16'd0, mem_wdata}, {16'd0, x});
      if (e_sp) begin
         check("R10", "spr idx", {25'd0, spr_idx}, {25'd0, ins[6:0]});
         check("R10", "spr data", {16'd0, spr_wdata}, {16'd0, x});
      end
   endtask

   logic [15:0] pat [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                            16'hFFFF, 16'h1234, 16'h0003, 16'hA5C6};

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "enables in reset", {25'd0, out_valid, wb_en, br_taken, mem_rd, mem_wr, spr_req, spr_write}, 32'd0);
      rst_n = 1'b1;
      check("R1", "enables after reset", {25'd0, out_valid, wb_en, br_taken, mem_rd, mem_wr, spr_req, spr_write}, 32'd0);
      for (int op = 0; op < 16; op++)
         for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++) begin
               logic [11:0] f;
               f = 12'((a * 389 + b * 97 + op * 13) & 12'hFFF);
               run({4'(op), f}, pat[a], pat[b], pat[(a + b * 3 + op) & 7], 1'b1);
            end
      // R2: instructions with in_valid low do nothing
      run(16'hA123, 16'd1, 16'd2, 16'd3, 1'b0);
      run(16'hC5F8, 16'd1, 16'd2, 16'd3, 1'b0);
      // R4 zero divisor, R6 extreme amounts, R11 unused opcodes
      run(16'h7345, 16'h1234, 16'h5678, 16'h0000, 1'b1);
      run(16'h5318, 16'hFFFF, 16'h8001, 16'h0000, 1'b1);
      run(16'h5317, 16'hFFFF, 16'h8001, 16'h0000, 1'b1);
      run(16'h9FFF, 16'h0000, 16'h0000, 16'h0000, 1'b1);
      run(16'hB000, 16'h0001, 16'h0001, 16'h0001, 1'b1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule